// File: doc/BRIEF.md
# Parallel ADC Sequencer

This block is the host-side controller for an external 12-bit, multichannel analog-to-digital converter that uses a parallel bus. For each sample it does the following:

- drives a channel address and commits it with a pulse on an active-low write strobe;
- waits until the converter has tracked its input for long enough, then raises a start line;
- waits for the converter's active-low end-of-conversion pulse;
- reads the result by pulling chip select and read low together.

Each result leaves the block on a valid/ready stream, paired with the channel number it belongs to.

While `run` is high, the sequencer steps through a programmable list of channels and wraps at a programmable last entry. Every interval is a parameter counted in clock cycles. The defaults assume a 125 MHz clock:

| Interval | Default | Time |
|---|---|---|
| Conversion | 200 cycles | 1.6 µs |
| Acquisition | 75 cycles | 600 ns |
| Read-to-start guard | 13 cycles | 100 ns |

A parameter selects the shorter acquisition variant instead. The end-of-conversion input crosses into the clock domain through a synchroniser. A conversion that never signals completion is abandoned after twice the conversion time.

Top module: `adc_par_seq`

## Requirements
- R1: During and straight after reset, `adc_wr_n`, `adc_cs_n` and `adc_rd_n` are high, and `adc_convst`, `m_valid` and `err_timeout` are low.
- R2: Before every start, `adc_addr` carries the selected channel for the whole time `adc_wr_n` is low. That low phase lasts WR_CYC cycles, and its rising edge comes before the start.
- R3: A start is a single-cycle high pulse on `adc_convst`. It rises only after at least the acquisition interval (ACQ_SLOW_CYC, or ACQ_FAST_CYC when FAST_TRACK=1) has passed since the previous falling edge of `adc_eoc_n`, or since reset.
- R4: A read drives `adc_cs_n` and `adc_rd_n` low together for exactly RD_CYC cycles. It happens only after a falling edge of `adc_eoc_n`, never while a conversion is in progress.
- R5: At least GUARD_CYC cycles pass between the end of a read (`adc_rd_n` rising) and the next rising edge of `adc_convst`.
- R6: A result appears as `m_valid` high, with `m_data` equal to the bus value sampled in the last read cycle and `m_chan` equal to the converted channel. All three hold steady until a cycle with `m_ready` high.
- R7: `adc_convst` never rises while `m_valid` is high.
- R8: Channel entry i is bits [i*CH_W +: CH_W] of `chan_list`. After entry i, the next entry is i+1. It is entry 0 instead when i is greater than or equal to `list_last`, or when i is the last slot. If `list_last` has been lowered below the pending index, the sequence restarts at entry 0.
- R9: If no falling edge of `adc_eoc_n` is detected within 2*CONV_CYC cycles after the start, the sequencer does three things:
  - it pulses `err_timeout` for one cycle, TIMEOUT+1 cycles after the cycle in which `adc_convst` was high;
  - it performs no read;
  - it retries the same list entry.
- R10: With `run` low, no new write strobe begins. A sample already under way completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Keep sequencing while high |
| chan_list | input | LIST_LEN*CH_W | Channel list, entry i at bits [i*CH_W +: CH_W] |
| list_last | input | IDX_W | Index of the last list entry used |
| adc_addr | output | CH_W | Channel address to the converter |
| adc_wr_n | output | 1 | Address write strobe, active low |
| adc_convst | output | 1 | Conversion start, rising edge starts |
| adc_eoc_n | input | 1 | End-of-conversion pulse, active low, asynchronous |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_db | input | DATA_W | Converter result bus |
| m_valid | output | 1 | Result stream valid |
| m_ready | input | 1 | Result stream ready |
| m_data | output | DATA_W | Result value |
| m_chan | output | CH_W | Channel of the result |
| err_timeout | output | 1 | One-cycle pulse on a missing end of conversion |

## Verification
Two events can land in the same cycle:

- the stream handshake that frees the output register;
- the end of the acquisition interval that permits the next start.

The start must follow the handshake and never come before it. Random `m_ready` patterns, including a long stall while the sequencer waits with acquisition already satisfied, make these two events cross in every order.

A behavioural converter model in the bench judges each start at the moment it happens. It counts any start made while a result is pending, and any start made too early after an end-of-conversion edge or after a read. A scoreboard matches every accepted result against the channel list and the model's conversion values.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WRITE = 3'd1,
      ST_TRACK = 3'd2,
      ST_START = 3'd3,
      ST_CONV  = 3'd4,
      ST_READ  = 3'd5
   } seq_st_t;
endpackage

// File: rtl/adc_eoc_edge.sv
module adc_eoc_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic eoc_n_i,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("adc_eoc_edge: STAGES must be at least 2");
   end

   // sync chain plus one extra flop for the edge compare
   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-1:0], eoc_n_i};
   end

   assign fall_o = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/adc_gap_timer.sv
module adc_gap_timer #(
   parameter int LIMIT     = 16,
   parameter bit INIT_DONE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   output logic done_o
);
   if (LIMIT < 1) begin : g_bad_limit
      $error("adc_gap_timer: LIMIT must be positive");
   end

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= INIT_DONE ? LIM : '0;
      else if (clr_i)      cnt <= '0;
      else if (cnt != LIM) cnt <= cnt + 1'b1;
   end

   assign done_o = (cnt == LIM);
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
   parameter int DATA_W = 12,
   parameter int CH_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [CH_W-1:0]   chan_i,
   input  logic              ready_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o,
   output logic [CH_W-1:0]   chan_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         data_o  <= '0;
         chan_o  <= '0;
      end else if (load_i) begin
         valid_o <= 1'b1;
         data_o  <= data_i;
         chan_o  <= chan_i;
      end else if (ready_i) begin
         valid_o <= 1'b0;
      end
   end
endmodule

// File: rtl/adc_par_seq.sv
module adc_par_seq
   import adc_seq_pkg::*;
#(
   parameter int DATA_W       = 12,
   parameter int CH_W         = 3,
   parameter int LIST_LEN     = 4,
   parameter int WR_CYC       = 3,
   parameter int RD_CYC       = 3,
   parameter int CONV_CYC     = 200,
   parameter int ACQ_SLOW_CYC = 75,
   parameter int ACQ_FAST_CYC = 50,
   parameter bit FAST_TRACK   = 1'b0,
   parameter int GUARD_CYC    = 13,
   parameter int SYNC_STAGES  = 2,
   localparam int IDX_W       = (LIST_LEN > 1) ? $clog2(LIST_LEN) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     run,
   input  logic [LIST_LEN*CH_W-1:0] chan_list,
   input  logic [IDX_W-1:0]         list_last,
   output logic [CH_W-1:0]          adc_addr,
   output logic                     adc_wr_n,
   output logic                     adc_convst,
   input  logic                     adc_eoc_n,
   output logic                     adc_cs_n,
   output logic                     adc_rd_n,
   input  logic [DATA_W-1:0]        adc_db,
   output logic                     m_valid,
   input  logic                     m_ready,
   output logic [DATA_W-1:0]        m_data,
   output logic [CH_W-1:0]          m_chan,
   output logic                     err_timeout
);
   localparam int TIMEOUT_CYC = 2 * CONV_CYC;
   localparam int CNT_W       = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CNT_W-1:0] WR_END  = CNT_W'(WR_CYC - 1);
   localparam logic [CNT_W-1:0] RD_END  = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] TMO_END = CNT_W'(TIMEOUT_CYC - 1);
   localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(LIST_LEN - 1);

   if (DATA_W < 1 || CH_W < 1 || LIST_LEN < 1) begin : g_bad_size
      $error("adc_par_seq: widths and list length must be positive");
   end
   if (WR_CYC < 1 || RD_CYC < 1 || CONV_CYC < 1 || GUARD_CYC < 1) begin : g_bad_time
      $error("adc_par_seq: interval parameters must be positive");
   end
   if (ACQ_SLOW_CYC < 1 || ACQ_FAST_CYC < 1) begin : g_bad_acq
      $error("adc_par_seq: acquisition intervals must be positive");
   end

   // unpack the channel list
   logic [CH_W-1:0] list_arr [LIST_LEN];
   for (genvar i = 0; i < LIST_LEN; i++) begin : g_list
      assign list_arr[i] = chan_list[i*CH_W +: CH_W];
   end

   seq_st_t          st;
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] idx, sel_q, cur_idx, idx_nxt;
   logic [CH_W-1:0]  addr_q;
   logic             err_q;
   logic             eoc_fall, trk_done, gap_done, load;

   adc_eoc_edge #(.STAGES(SYNC_STAGES)) u_eoc (
      .clk(clk), .rst_n(rst_n), .eoc_n_i(adc_eoc_n), .fall_o(eoc_fall)
   );

   // acquisition variant chosen at elaboration
   if (FAST_TRACK) begin : g_trk
      adc_gap_timer #(.LIMIT(ACQ_FAST_CYC), .INIT_DONE(1'b0)) u_trk (
         .clk(clk), .rst_n(rst_n), .clr_i(eoc_fall), .done_o(trk_done)
      );
   end else begin : g_trk
      adc_gap_timer #(.LIMIT(ACQ_SLOW_CYC), .INIT_DONE(1'b0)) u_trk (
         .clk(clk), .rst_n(rst_n), .clr_i(eoc_fall), .done_o(trk_done)
      );
   end

   // read-to-start guard, satisfied out of reset
   adc_gap_timer #(.LIMIT(GUARD_CYC), .INIT_DONE(1'b1)) u_gap (
      .clk(clk), .rst_n(rst_n), .clr_i(st == ST_READ), .done_o(gap_done)
   );

   always_comb begin
      cur_idx = (idx > list_last || idx > LAST_SLOT) ? '0 : idx;
      idx_nxt = (sel_q >= list_last || sel_q == LAST_SLOT) ? '0 : sel_q + 1'b1;
   end

   assign load = (st == ST_READ) && (cnt == RD_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         idx    <= '0;
         sel_q  <= '0;
         addr_q <= '0;
         err_q  <= 1'b0;
      end else begin
         err_q <= 1'b0;
         unique case (st)
            ST_IDLE: if (run) begin
               sel_q  <= cur_idx;
               addr_q <= list_arr[cur_idx];
               cnt    <= '0;
               st     <= ST_WRITE;
            end
            ST_WRITE: if (cnt == WR_END) begin
               cnt <= '0;
               st  <= ST_TRACK;
            end else begin
               cnt <= cnt + 1'b1;
            end
            ST_TRACK: if (trk_done && gap_done && !m_valid) st <= ST_START;
            ST_START: begin
               cnt <= '0;
               st  <= ST_CONV;
            end
            ST_CONV: if (eoc_fall) begin
               cnt <= '0;
               st  <= ST_READ;
            end else if (cnt == TMO_END) begin
               err_q <= 1'b1;
               st    <= ST_IDLE;
            end else begin
               cnt <= cnt + 1'b1;
            end
            ST_READ: if (cnt == RD_END) begin
               idx <= idx_nxt;
               st  <= ST_IDLE;
            end else begin
               cnt <= cnt + 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   adc_result_hold #(.DATA_W(DATA_W), .CH_W(CH_W)) u_out (
      .clk(clk), .rst_n(rst_n), .load_i(load), .data_i(adc_db), .chan_i(addr_q),
      .ready_i(m_ready), .valid_o(m_valid), .data_o(m_data), .chan_o(m_chan)
   );

   assign adc_addr    = addr_q;
   assign adc_wr_n    = (st != ST_WRITE);
   assign adc_convst  = (st == ST_START);
   assign adc_cs_n    = (st != ST_READ);
   assign adc_rd_n    = (st != ST_READ);
   assign err_timeout = err_q;
endmodule

// File: rtl/adc_par_seq_chk.sv
module adc_par_seq_chk #(
   parameter int DATA_W    = 12,
   parameter int CH_W      = 3,
   parameter int GUARD_CYC = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CH_W-1:0]   adc_addr,
   input logic              adc_wr_n,
   input logic              adc_convst,
   input logic              adc_cs_n,
   input logic              adc_rd_n,
   input logic              m_valid,
   input logic              m_ready,
   input logic [DATA_W-1:0] m_data,
   input logic [CH_W-1:0]   m_chan,
   input logic              err_timeout
);
   localparam int GW = $clog2(GUARD_CYC + 1);
   localparam logic [GW-1:0] GLIM = GW'(GUARD_CYC);

   logic [GW-1:0] since_rd;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             since_rd <= GLIM;
      else if (!adc_rd_n)     since_rd <= '0;
      else if (since_rd != GLIM) since_rd <= since_rd + 1'b1;
   end

   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!adc_wr_n && !$past(adc_wr_n)) |-> $stable(adc_addr));

   assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      adc_convst |=> !adc_convst);

   assert_read_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!adc_rd_n || !adc_cs_n) |-> (!adc_convst && adc_wr_n));

   assert_read_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_convst) |-> (since_rd == GLIM));

   assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_chan)));

   assert_no_start_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_convst) |-> !m_valid);

   assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_timeout |=> !err_timeout);
endmodule

bind adc_par_seq adc_par_seq_chk #(
   .DATA_W(DATA_W), .CH_W(CH_W), .GUARD_CYC(GUARD_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .adc_addr(adc_addr), .adc_wr_n(adc_wr_n),
   .adc_convst(adc_convst), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
   .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_chan(m_chan),
   .err_timeout(err_timeout)
);

// File: tb/adc_par_seq_bench.sv
module adc_par_seq_bench;
   localparam int DW = 12, CW = 3, LL = 4, IW = 2;
   localparam int WRC = 3, RDC = 3, CONV = 200, ACQ = 75, GUARD = 13;
   localparam int TMO = 2 * CONV;

   logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
   logic [LL*CW-1:0] chan_list;
   logic [IW-1:0]    list_last;
   logic [CW-1:0]    adc_addr, m_chan;
   logic             adc_wr_n, adc_convst, adc_cs_n, adc_rd_n, m_valid, err_timeout;
   logic             adc_eoc_n = 1'b1, m_ready = 1'b0;
   logic [DW-1:0]    adc_db = '0, m_data;

   always #4 clk = ~clk;

   adc_par_seq u_adc_par_seq (
      .clk(clk), .rst_n(rst_n), .run(run), .chan_list(chan_list), .list_last(list_last),
      .adc_addr(adc_addr), .adc_wr_n(adc_wr_n), .adc_convst(adc_convst),
      .adc_eoc_n(adc_eoc_n), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .adc_db(adc_db),
      .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_chan(m_chan),
      .err_timeout(err_timeout)
   );

   int n_checks = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] conv_val(input int ch, input int k);
      return DW'(((k * 37) + (ch * 301)) ^ 32'h5A5);
   endfunction

   // converter model, rule monitor and scoreboard, all at the falling edge
   int cyc = 0, k_conv = 0, busy_cnt = 0, eoc_lo = 0, rd_len = 0;
   int last_eoc = 0, last_rd_end = -1000, last_start = 0;
   int v_wr = 0, v_acq = 0, v_rd = 0, v_guard = 0, v_bp = 0, v_stab = 0, v_pulse = 0;
   int err_cnt = 0, err_gap = 0, wr_falls = 0, n_res = 0, exp_idx = 0;
   int ready_mode = 0;
   bit busy = 0, wr_ok = 0, no_eoc = 0, hold_prev = 0;
   logic p_wr_n = 1, p_convst = 0, p_rd_n = 1;
   logic [CW-1:0] p_addr = '0, lat_addr = '0;
   logic [DW-1:0] cur_val = '0, h_data = '0;
   logic [CW-1:0] h_chan = '0;

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         last_eoc = cyc;
      end else begin
         if (!adc_wr_n && !p_wr_n && adc_addr != p_addr) v_wr++;
         if (!p_wr_n && adc_wr_n) begin wr_ok = 1; lat_addr = adc_addr; end
         if (p_wr_n && !adc_wr_n) wr_falls++;
         if (adc_convst && p_convst) v_pulse++;
         if (adc_convst && !p_convst) begin
            if (!wr_ok) v_wr++;
            wr_ok = 0;
            if (cyc - last_eoc < ACQ) v_acq++;
            if (cyc - last_rd_end < GUARD) v_guard++;
            if (m_valid) v_bp++;
            busy = 1; busy_cnt = 0; last_start = cyc;
            cur_val = conv_val(int'(lat_addr), k_conv);
         end else if (busy) begin
            busy_cnt++;
            if (busy_cnt == CONV) begin
               busy = 0;
               if (!no_eoc) begin
                  adc_eoc_n = 1'b0; eoc_lo = 2; k_conv++; last_eoc = cyc;
               end
            end
         end
         if (eoc_lo > 0) begin
            eoc_lo--;
            if (eoc_lo == 0) adc_eoc_n = 1'b1;
         end
         if (!adc_rd_n && busy) v_rd++;
         if (adc_rd_n != adc_cs_n) v_rd++;
         if (!adc_rd_n) rd_len++;
         if (!p_rd_n && adc_rd_n) begin
            if (rd_len != RDC) v_rd++;
            rd_len = 0; last_rd_end = cyc;
         end
         adc_db = (!adc_rd_n && !adc_cs_n) ? cur_val : '0;
         if (err_timeout) begin err_cnt++; err_gap = cyc - last_start; end
         // stream side
         if (hold_prev) begin
            if (!m_valid || m_data != h_data || m_chan != h_chan) v_stab++;
         end
         case (ready_mode)
            0: m_ready = 1'b1;
            1: m_ready = ($urandom % 3) != 0;
            default: m_ready = 1'b0;
         endcase
         if (m_valid && m_ready) begin
            int e_ch;
            if (exp_idx > int'(list_last)) exp_idx = 0;
            e_ch = int'(chan_list[exp_idx*CW +: CW]);
            chk(int'(m_chan) == e_ch, "R8 channel order", int'(m_chan), e_ch);
            chk(m_data == conv_val(e_ch, n_res), "R6 result data", int'(m_data),
                int'(conv_val(e_ch, n_res)));
            n_res++;
            exp_idx = (exp_idx >= int'(list_last) || exp_idx == LL - 1) ? 0 : exp_idx + 1;
         end
         hold_prev = m_valid && !m_ready;
         h_data = m_data; h_chan = m_chan;
      end
      p_wr_n = adc_wr_n; p_convst = adc_convst; p_rd_n = adc_rd_n; p_addr = adc_addr;
   end

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         finish_up();
      end
   end

   initial begin
      int base, f0;
      void'($urandom(32'd4711));
      chan_list = {3'd5, 3'd2, 3'd7, 3'd1};
      list_last = 2'd3;
      repeat (5) @(negedge clk);
      chk(adc_wr_n == 1'b1, "R1 wr_n idle", int'(adc_wr_n), 1);
      chk(adc_cs_n == 1'b1 && adc_rd_n == 1'b1, "R1 cs/rd idle", int'({adc_cs_n, adc_rd_n}), 3);
      chk(adc_convst == 1'b0, "R1 convst low", int'(adc_convst), 0);
      chk(m_valid == 1'b0 && err_timeout == 1'b0, "R1 valid/err low",
          int'({m_valid, err_timeout}), 0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk(adc_wr_n && adc_rd_n && !adc_convst && !m_valid, "R1 after release",
          int'({adc_wr_n, adc_rd_n, adc_convst, m_valid}), 12);

      // full list, ready always high
      run = 1'b1; ready_mode = 0;
      while (n_res < 8) @(negedge clk);
      // random backpressure
      ready_mode = 1;
      while (n_res < 20) @(negedge clk);
      // long stall: result must be held and no start issued
      ready_mode = 2;
      repeat (1500) @(negedge clk);
      chk(m_valid == 1'b1, "R6 result held during stall", int'(m_valid), 1);
      chk(v_bp == 0, "R7 no start while pending", v_bp, 0);
      ready_mode = 1;
      while (n_res < 26) @(negedge clk);

      // stop
      run = 1'b0; ready_mode = 0;
      repeat (800) @(negedge clk);
      f0 = wr_falls;
      repeat (1000) @(negedge clk);
      chk(wr_falls == f0, "R10 no write strobe with run low", wr_falls - f0, 0);
      chk(m_valid == 1'b0, "R10 stream drained", int'(m_valid), 0);

      // single-entry list
      chan_list[2:0] = 3'd6; list_last = 2'd0;
      run = 1'b1; ready_mode = 1; base = n_res;
      while (n_res < base + 6) @(negedge clk);

      // missing end of conversion
      list_last = 2'd2;
      base = n_res;
      while (n_res < base + 2) @(negedge clk);
      no_eoc = 1;
      while (err_cnt == 0) @(negedge clk);
      no_eoc = 0;
      chk(err_gap == TMO + 1, "R9 timeout delay", err_gap, TMO + 1);
      base = n_res;
      while (n_res < base + 8) @(negedge clk);
      chk(err_cnt == 1, "R9 single error pulse", err_cnt, 1);

      chk(v_wr == 0, "R2 address write before start", v_wr, 0);
      chk(v_acq == 0, "R3 acquisition interval", v_acq, 0);
      chk(v_pulse == 0, "R3 single-cycle start", v_pulse, 0);
      chk(v_rd == 0, "R4 read placement and width", v_rd, 0);
      chk(v_guard == 0, "R5 read-to-start guard", v_guard, 0);
      chk(v_stab == 0, "R6 stream stable under backpressure", v_stab, 0);
      chk(v_bp == 0, "R7 no start while pending", v_bp, 0);
      done = 1;
      finish_up();
   end
endmodule